// File: doc/BRIEF.md
# SPI Mailbox Data Memory

This block is a processor's 64-word data memory. It doubles as the meeting point between that processor and an SPI transfer engine. Most word addresses are ordinary read/write storage. Two fixed word addresses are one-way mailboxes:

- **Word 60** is written only by the processor. Its fields feed the engine continuously: the byte to send, the clock polarity and phase, a clock divider and a slave number. Every processor write to it starts a transfer.
- **Word 61** is written only by the engine side. It holds the last received byte and a busy flag, which the processor polls.

The processor port reads combinationally and writes on the rising clock edge. A write to word 60 produces a one-cycle start pulse toward the engine and sets the busy flag on the same edge. The processor then carries on with other work. It polls word 61 until bit 31 drops, then takes the received byte from its low bits. The engine signals the end of a transfer with a one-cycle done strobe carrying the received byte.

Top module: `spi_mailbox_mem`

## Requirements
- R1: After the asynchronous active-low reset, word 60 and word 61 both read as zero, every configuration output is zero, and the start output is low.
- R2: A write to any address other than 60 and 61 takes effect at the rising edge. A later read of that address returns the written word combinationally.
- R3: A write to word 60 stores the word, and the configuration outputs present its fields. Bits [7:0] are the transmit byte, bit 8 is clock polarity, bit 9 is clock phase, bits [17:10] are the clock divider, and bits [19:18] are the slave number.
- R4: Each processor write to word 60 raises the start output for exactly the one cycle after the write edge. Start is never high without such a write.
- R5: A read of word 61 in the cycle right after a write to word 60 already shows busy, which is bit 31 set to 1.
- R6: A done strobe from the engine stores the received byte in bits [7:0] of word 61 and clears bit 31. Bits [30:8] of word 61 always read zero.
- R7: Processor writes to word 61 are ignored; the word reads back unchanged.
- R8: The engine side cannot change word 60: a done strobe leaves its value and the configuration outputs unchanged.
- R9: When a write to word 60 and a done strobe land on the same edge, word 61 captures the received byte and busy stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 6 | Processor word address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Combinational read data for cpu_addr |
| eng_tx | output | 8 | Transmit byte from word 60 |
| eng_cpol | output | 1 | Clock polarity from word 60 |
| eng_cpha | output | 1 | Clock phase from word 60 |
| eng_div | output | 8 | Clock divider from word 60 |
| eng_sel | output | 2 | Slave number from word 60 |
| eng_start | output | 1 | One-cycle start pulse |
| eng_done | input | 1 | Engine end-of-transfer strobe |
| eng_rx | input | 8 | Received byte, valid with eng_done |

## Verification
The bench builds the block with its default parameters. These are 6 address bits, 32-bit words, the mailboxes at 60 and 61, an 8-bit byte, an 8-bit divider and a 2-bit slave field. With these values the exact field positions of R3 can be checked bit for bit. Both neighbours of the mailboxes (59 and 62) and both ends of the space (0 and 63) are within reach as ordinary storage. Directed cases then cover a write immediately followed by a busy poll, a write to the read-only word, and a start coinciding with a done strobe.

// File: rtl/spi_mailbox_mem.sv
module spi_mailbox_mem #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int DIV_W    = 8,
  parameter int SEL_W    = 2,
  parameter int CFG_ADDR = 60,
  parameter int STA_ADDR = 61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [BYTE_W-1:0] eng_tx,
  output logic              eng_cpol,
  output logic              eng_cpha,
  output logic [DIV_W-1:0]  eng_div,
  output logic [SEL_W-1:0]  eng_sel,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CPOL_B  = BYTE_W;
  localparam int CPHA_B  = BYTE_W + 1;
  localparam int DIV_LO  = BYTE_W + 2;
  localparam int SEL_LO  = DIV_LO + DIV_W;
  localparam int PAD_W   = DATA_W - 1 - BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] cfg_q;
  logic [BYTE_W-1:0] rx_q;
  logic              busy_q;
  logic              start_q;

  wire hit_cfg = (cpu_addr == ADDR_W'(CFG_ADDR));
  wire hit_sta = (cpu_addr == ADDR_W'(STA_ADDR));
  wire cfg_wr  = cpu_we && hit_cfg;
  wire ram_wr  = cpu_we && !hit_cfg && !hit_sta;

  wire [DATA_W-1:0] sta_word = {busy_q, {PAD_W{1'b0}}, rx_q};

  always_ff @(posedge clk)
    if (ram_wr) mem[cpu_addr] <= cpu_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q   <= '0;
      rx_q    <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= cfg_wr;
      if (cfg_wr) cfg_q <= cpu_wdata;
      if (eng_done) rx_q <= eng_rx;
      if (cfg_wr) busy_q <= 1'b1;
      else if (eng_done) busy_q <= 1'b0;
    end

  assign cpu_rdata = hit_cfg ? cfg_q : hit_sta ? sta_word : mem[cpu_addr];

  assign eng_tx    = cfg_q[BYTE_W-1:0];
  assign eng_cpol  = cfg_q[CPOL_B];
  assign eng_cpha  = cfg_q[CPHA_B];
  assign eng_div   = cfg_q[DIV_LO +: DIV_W];
  assign eng_sel   = cfg_q[SEL_LO +: SEL_W];
  assign eng_start = start_q;
endmodule

module spi_mailbox_mem_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int CFG_ADDR = 60,
  parameter int STA_ADDR = 61
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              eng_start,
  input logic              eng_done,
  input logic [BYTE_W-1:0] eng_rx,
  input logic [DATA_W-1:0] cfg_q,
  input logic [BYTE_W-1:0] rx_q,
  input logic              busy_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  wire cfg_w = cpu_we && (cpu_addr == ADDR_W'(CFG_ADDR));

  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && eng_start |-> $past(cfg_w));
  p_busy_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy_q);
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && !cfg_w |=> !busy_q && rx_q == $past(eng_rx));
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr == ADDR_W'(STA_ADDR) |-> cpu_rdata[DATA_W-2:BYTE_W] == '0);
  p_sta_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_done && !cfg_w |=> $stable(rx_q) && $stable(busy_q));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_w |=> $stable(cfg_q));
  p_both_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w && eng_done |=> busy_q);
endmodule

bind spi_mailbox_mem spi_mailbox_mem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
  .CFG_ADDR(CFG_ADDR), .STA_ADDR(STA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_rdata(cpu_rdata), .eng_start(eng_start), .eng_done(eng_done),
  .eng_rx(eng_rx), .cfg_q(cfg_q), .rx_q(rx_q), .busy_q(busy_q)
);

// File: tb/sim_spi_mailbox_mem.sv
`timescale 1ns/1ps
module sim_spi_mailbox_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [7:0]  eng_tx;
  logic        eng_cpol, eng_cpha;
  logic [7:0]  eng_div;
  logic [1:0]  eng_sel;
  logic        eng_start;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_rx = '0;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  spi_mailbox_mem u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_tx(eng_tx),
    .eng_cpol(eng_cpol), .eng_cpha(eng_cpha), .eng_div(eng_div),
    .eng_sel(eng_sel), .eng_start(eng_start), .eng_done(eng_done),
    .eng_rx(eng_rx)
  );

  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {6'd0,  32'h0000_0001}, {6'd1,  32'hDEAD_BEEF},
    {6'd17, 32'h1234_5678}, {6'd31, 32'hFFFF_FFFF},
    {6'd32, 32'h8000_0000}, {6'd59, 32'hA5A5_5A5A},
    {6'd62, 32'h0F0F_F0F0}, {6'd63, 32'hCAFE_F00D}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, logic done_too, logic [7:0] rx);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
    eng_done = done_too; eng_rx = rx;
    @(posedge clk); #1;
    cpu_we = 1'b0; eng_done = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    cpu_addr = a; #0.5; d = cpu_rdata;
  endtask

  task automatic strobe(logic [7:0] rx);
    @(negedge clk);
    eng_done = 1'b1; eng_rx = rx;
    @(posedge clk); #1;
    eng_done = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(6'd60, r); check("R1 cfg word", r, 32'h0);
    rd(6'd61, r); check("R1 status word", r, 32'h0);
    check("R1 start", {31'b0, eng_start}, 32'h0);
    check("R1 fields", {eng_sel, eng_div, eng_cpha, eng_cpol, eng_tx}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 general storage table
    for (int i = 0; i < NV; i++) wr(VEC[i][37:32], VEC[i][31:0], 1'b0, 8'h0);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][37:32], r);
      check("R2 readback", r, VEC[i][31:0]);
    end

    // R3/R4/R5 configuration write
    wr(6'd60, 32'h000C_B1A5, 1'b0, 8'h0);
    check("R4 start high", {31'b0, eng_start}, 32'h1);
    rd(6'd61, r); check("R5 busy after write", r, 32'h8000_0000);
    check("R3 tx", {24'b0, eng_tx}, 32'hA5);
    check("R3 cpol/cpha", {30'b0, eng_cpha, eng_cpol}, 32'h1);
    check("R3 div", {24'b0, eng_div}, 32'h2C);
    check("R3 sel", {30'b0, eng_sel}, 32'h3);
    rd(6'd60, r); check("R3 word", r, 32'h000C_B1A5);
    @(posedge clk); #1;
    check("R4 start one cycle", {31'b0, eng_start}, 32'h0);

    // R6/R8 done strobe
    strobe(8'h3C);
    rd(6'd61, r); check("R6 rx and busy clear", r, 32'h0000_003C);
    rd(6'd60, r); check("R8 cfg untouched", r, 32'h000C_B1A5);
    check("R8 tx untouched", {24'b0, eng_tx}, 32'hA5);

    // R7 write to status ignored
    wr(6'd61, 32'hFFFF_FFFF, 1'b0, 8'h0);
    rd(6'd61, r); check("R7 status write ignored", r, 32'h0000_003C);
    check("R7 no start", {31'b0, eng_start}, 32'h0);

    // R9 start and done together
    wr(6'd60, 32'h0000_0312, 1'b1, 8'hC3);
    rd(6'd61, r); check("R9 busy kept, rx captured", r, 32'h8000_00C3);
    check("R9 start", {31'b0, eng_start}, 32'h1);
    check("R3 phase field", {30'b0, eng_cpha, eng_cpol}, 32'h3);
    strobe(8'h81);
    rd(6'd61, r); check("R6 second rx", r, 32'h0000_0081);

    // R2 neighbours unaffected by mailbox traffic
    rd(6'd59, r); check("R2 neighbour 59", r, 32'hA5A5_5A5A);
    rd(6'd62, r); check("R2 neighbour 62", r, 32'h0F0F_F0F0);

    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule